// File: doc/BRIEF.md
# Indexed Handler-Call Branch Unit

This unit computes the results of a compact family of handler-call branches. A VM runtime keeps a table of equal-size handler routines, each 32 bytes long, starting at a configurable handler base address. A call instruction names one routine by its index. The unit returns the branch target as base plus 32 times the index.

The instruction family has four forms, set by two decoded flags:

- The link flag says whether the return address is written to the link register.
- The param flag selects the parameterised forms. These forms also pass a small compile-time constant, zero-extended, to a dedicated parameter register. The low general registers are left untouched.

The parameterised forms can reach only the first 32 handlers. Their constant is 5 bits wide when linking and 3 bits wide when not linking. The decoder hands over fixed-width fields, and any bits beyond the width allowed for a form are dropped.

The target and register writes are computed combinationally from the decoded fields, the next-instruction address and the handler base. They are then registered. They appear at the outputs for exactly one cycle, one cycle after the request.

Top module: `hcall_branch_unit`

## Requirements
- R1: A request with `req_valid` high at a rising edge produces its result on the outputs with `out_valid` high for the following cycle only. Whenever `out_valid` is low, including after reset, every other output is zero.
- R2: With `req_param` = 0, the target is `handler_base + 32*req_handler` using all 8 handler bits (0 to 255), and the sum wraps modulo 2^32.
- R3: With `req_link` = 1, `lr_we` is high and `lr_data` is `next_pc` with bit 0 forced to 1. With `req_link` = 0, `lr_we` and `lr_data` stay zero.
- R4: With `req_param` = 1, the target is `handler_base + 32*req_handler[4:0]`; bits [7:5] of `req_handler` have no effect.
- R5: In the parameterised linking form (`req_link`=1, `req_param`=1), `pr_we` is high and `pr_data` is `req_value[4:0]` zero-extended to 32 bits.
- R6: In the parameterised non-linking form (`req_link`=0, `req_param`=1), `pr_we` is high and `pr_data` is `req_value[2:0]` zero-extended; bits [4:3] of `req_value` have no effect.
- R7: With `req_param` = 0, `pr_we` and `pr_data` stay zero whatever `req_value` holds.
- R8: Requests on consecutive cycles each produce their own result on consecutive cycles, in order, with no cycle lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A decoded handler call is present |
| req_link | input | 1 | 1 = write return address to link register |
| req_param | input | 1 | 1 = parameterised form |
| req_handler | input | 8 | Handler index (low 5 bits used in parameterised forms) |
| req_value | input | 5 | Parameter constant (low 3 bits used when not linking) |
| next_pc | input | 32 | Address of the next instruction |
| handler_base | input | 32 | Base address of the handler table |
| out_valid | output | 1 | Result valid for this cycle |
| out_target | output | 32 | Branch target address |
| lr_we | output | 1 | Link register write enable |
| lr_data | output | 32 | Return address to write |
| pr_we | output | 1 | Parameter register write enable |
| pr_data | output | 32 | Zero-extended parameter to write |

## Verification
The bench sets the dropped upper bits of both the handler field and the parameter field. A design that masked by the wrong form would send parameterised calls beyond handler 31, or leak bits 4:3 of a short parameter into the register. It places the table near the top of the address space so the target must wrap; a truncated adder or a shift by the wrong amount lands elsewhere. Back-to-back requests of alternating forms expose a stale write enable or a result held over from the previous call. The return address is checked on even and odd next-instruction addresses to catch a missing state bit.

// File: rtl/hcb_pkg.sv
package hcb_pkg;

    localparam int ADDR_W     = 32;
    localparam int HNUM_W     = 8;
    localparam int PHNUM_W    = 5;
    localparam int PLONG_W    = 5;
    localparam int PSHORT_W   = 3;
    localparam int SLOT_SHIFT = 5;

    typedef enum logic [1:0] {
        FORM_PLAIN     = 2'b00,
        FORM_LINK      = 2'b01,
        FORM_PARM      = 2'b10,
        FORM_PARM_LINK = 2'b11
    } form_e;

    typedef struct packed {
        form_e               form;
        logic                link;
        logic                param;
        logic [HNUM_W-1:0]   index;
        logic [PLONG_W-1:0]  value;
    } dec_t;

    typedef struct packed {
        logic                valid;
        logic [ADDR_W-1:0]   target;
        logic                lr_we;
        logic [ADDR_W-1:0]   lr_data;
        logic                pr_we;
        logic [ADDR_W-1:0]   pr_data;
    } res_t;

    function automatic form_e form_of(input logic link, input logic param);
        return form_e'({param, link});
    endfunction

    function automatic logic [ADDR_W-1:0] ret_addr(input logic [ADDR_W-1:0] npc);
        return {npc[ADDR_W-1:1], 1'b1};
    endfunction

endpackage

// File: rtl/hcb_decode.sv
module hcb_decode
    import hcb_pkg::*;
(
    input  logic               link,
    input  logic               param,
    input  logic [HNUM_W-1:0]  handler,
    input  logic [PLONG_W-1:0] value,
    output dec_t               dec
);
    localparam int IDX_PAD = HNUM_W - PHNUM_W;
    localparam int VAL_PAD = PLONG_W - PSHORT_W;

    form_e form;

    always_comb begin
        form       = form_of(link, param);
        dec.form   = form;
        dec.link   = link;
        dec.param  = param;
        dec.index  = handler;
        dec.value  = '0;
        unique case (form)
            FORM_PLAIN, FORM_LINK: begin
                dec.index = handler;
                dec.value = '0;
            end
            FORM_PARM: begin
                dec.index = {{IDX_PAD{1'b0}}, handler[PHNUM_W-1:0]};
                dec.value = {{VAL_PAD{1'b0}}, value[PSHORT_W-1:0]};
            end
            FORM_PARM_LINK: begin
                dec.index = {{IDX_PAD{1'b0}}, handler[PHNUM_W-1:0]};
                dec.value = value;
            end
            default: begin
                dec.index = handler;
                dec.value = '0;
            end
        endcase
    end

    always_comb begin
        if (param) begin
            assert (dec.index < (HNUM_W'(1) << PHNUM_W))
                else $error("p_param_index_r4: index beyond short table");
        end
    end

endmodule

// File: rtl/hcb_target.sv
module hcb_target
    import hcb_pkg::*;
#(
    parameter int SHIFT = SLOT_SHIFT
)(
    input  logic [ADDR_W-1:0] base,
    input  logic [HNUM_W-1:0] index,
    output logic [ADDR_W-1:0] target
);
    localparam int PAD = ADDR_W - HNUM_W;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = {{PAD{1'b0}}, index} << SHIFT;
        target = base + offset;
    end

endmodule

// File: rtl/hcb_writeback.sv
module hcb_writeback
    import hcb_pkg::*;
(
    input  dec_t              dec,
    input  logic [ADDR_W-1:0] npc,
    output logic              lr_we,
    output logic [ADDR_W-1:0] lr_data,
    output logic              pr_we,
    output logic [ADDR_W-1:0] pr_data
);
    localparam int PAD = ADDR_W - PLONG_W;

    always_comb begin
        lr_we   = dec.link;
        lr_data = dec.link ? ret_addr(npc) : '0;
        pr_we   = dec.param;
        pr_data = dec.param ? {{PAD{1'b0}}, dec.value} : '0;
    end

endmodule

// File: rtl/hcall_branch_unit.sv
module hcall_branch_unit
    import hcb_pkg::*;
#(
    parameter int SHIFT = SLOT_SHIFT
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_link,
    input  logic               req_param,
    input  logic [HNUM_W-1:0]  req_handler,
    input  logic [PLONG_W-1:0] req_value,
    input  logic [ADDR_W-1:0]  next_pc,
    input  logic [ADDR_W-1:0]  handler_base,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_target,
    output logic               lr_we,
    output logic [ADDR_W-1:0]  lr_data,
    output logic               pr_we,
    output logic [ADDR_W-1:0]  pr_data
);
    localparam logic [ADDR_W-1:0] PARM_SPAN  = ADDR_W'(1) << (PHNUM_W + SHIFT);
    localparam logic [ADDR_W-1:0] SHORT_LIM  = ADDR_W'(1) << PSHORT_W;
    localparam logic [ADDR_W-1:0] LONG_LIM   = ADDR_W'(1) << PLONG_W;

    dec_t dec;
    res_t res_d, res_q;

    hcb_decode u_decode (
        .link    (req_link),
        .param   (req_param),
        .handler (req_handler),
        .value   (req_value),
        .dec     (dec)
    );

    hcb_target #(.SHIFT(SHIFT)) u_target (
        .base   (handler_base),
        .index  (dec.index),
        .target (res_d.target)
    );

    hcb_writeback u_wb (
        .dec     (dec),
        .npc     (next_pc),
        .lr_we   (res_d.lr_we),
        .lr_data (res_d.lr_data),
        .pr_we   (res_d.pr_we),
        .pr_data (res_d.pr_data)
    );

    assign res_d.valid = 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (req_valid) begin
            res_q <= res_d;
        end else begin
            res_q <= '0;
        end
    end

    assign out_valid  = res_q.valid;
    assign out_target = res_q.target;
    assign lr_we      = res_q.lr_we;
    assign lr_data    = res_q.lr_data;
    assign pr_we      = res_q.pr_we;
    assign pr_data    = res_q.pr_data;

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(req_valid));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!lr_we && !pr_we && out_target == '0));

    p_link_only_r3: assert property (@(posedge clk) disable iff (rst)
        lr_we |-> (out_valid && $past(req_link) && lr_data[0]));

    p_slot_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_target[SHIFT-1:0] == $past(handler_base[SHIFT-1:0]));

    p_short_table_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(req_param)) |-> (out_target - $past(handler_base)) < PARM_SPAN);

    p_long_param_r5: assert property (@(posedge clk) disable iff (rst)
        (pr_we && $past(req_link)) |-> pr_data < LONG_LIM);

    p_short_param_r6: assert property (@(posedge clk) disable iff (rst)
        (pr_we && !$past(req_link)) |-> pr_data < SHORT_LIM);

    p_param_only_r7: assert property (@(posedge clk) disable iff (rst)
        pr_we |-> (out_valid && $past(req_param)));

endmodule

// File: tb/hcall_branch_unit_tb_top.sv
module hcall_branch_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_link = 1'b0;
    logic        req_param = 1'b0;
    logic [7:0]  req_handler = '0;
    logic [4:0]  req_value = '0;
    logic [31:0] next_pc = '0;
    logic [31:0] handler_base = '0;
    logic        out_valid;
    logic [31:0] out_target;
    logic        lr_we;
    logic [31:0] lr_data;
    logic        pr_we;
    logic [31:0] pr_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] target;
        logic        lr_we;
        logic [31:0] lr_data;
        logic        pr_we;
        logic [31:0] pr_data;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    hcall_branch_unit dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_link(req_link),
        .req_param(req_param), .req_handler(req_handler), .req_value(req_value),
        .next_pc(next_pc), .handler_base(handler_base), .out_valid(out_valid),
        .out_target(out_target), .lr_we(lr_we), .lr_data(lr_data),
        .pr_we(pr_we), .pr_data(pr_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic l, input logic p, input logic [7:0] h,
                         input logic [4:0] v, input logic [31:0] npc,
                         input logic [31:0] base, input string tag);
        exp_t e;
        logic [7:0] idx;
        @(negedge clk);
        req_valid = 1'b1; req_link = l; req_param = p;
        req_handler = h; req_value = v; next_pc = npc; handler_base = base;
        idx       = p ? {3'b000, h[4:0]} : h;
        e.target  = base + ({24'b0, idx} * 32'd32);
        e.lr_we   = l;
        e.lr_data = l ? {npc[31:1], 1'b1} : 32'h0;
        e.pr_we   = p;
        e.pr_data = !p ? 32'h0 : (l ? {27'b0, v} : {29'b0, v[2:0]});
        e.tag     = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_handler = 8'hFF; req_value = 5'h1F; req_link = 1'b1; req_param = 1'b1;
        end
    endtask

    task automatic monitor();
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (done) break;
            if (sb.size() != 0) begin
                e = sb.pop_front();
                check(out_valid === 1'b1, e.tag, "out_valid", {31'b0, out_valid}, 32'h1);
                check(out_target === e.target, e.tag, "out_target", out_target, e.target);
                check(lr_we === e.lr_we, e.tag, "lr_we", {31'b0, lr_we}, {31'b0, e.lr_we});
                check(lr_data === e.lr_data, e.tag, "lr_data", lr_data, e.lr_data);
                check(pr_we === e.pr_we, e.tag, "pr_we", {31'b0, pr_we}, {31'b0, e.pr_we});
                check(pr_data === e.pr_data, e.tag, "pr_data", pr_data, e.pr_data);
            end else begin
                // R1: idle cycles show nothing
                check(out_valid === 1'b0 && lr_we === 1'b0 && pr_we === 1'b0 &&
                      out_target === 32'h0 && lr_data === 32'h0 && pr_data === 32'h0,
                      "R1", "idle outputs", out_target, 32'h0);
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - (fails > checks ? checks : fails), checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(out_valid === 1'b0 && out_target === 32'h0 && lr_we === 1'b0 &&
              pr_we === 1'b0 && lr_data === 32'h0 && pr_data === 32'h0,
              "R1", "reset outputs", out_target, 32'h0);
        fork monitor(); join_none
        // R2 plain form, full 8-bit index
        issue(0, 0, 8'd0,   5'h1F, 32'h0000_1002, 32'h0001_0000, "R2");
        idle(1);
        issue(0, 0, 8'd255, 5'h15, 32'h0000_2000, 32'h0002_0000, "R2");
        idle(2);
        // R2 wrap at the top of the address space
        issue(0, 0, 8'd255, 5'h00, 32'h0000_3000, 32'hFFFF_FFE0, "R2");
        idle(1);
        // R3 linking forms, even and odd next_pc
        issue(1, 0, 8'd130, 5'h00, 32'h0000_4446, 32'h0800_0000, "R3");
        issue(1, 0, 8'd7,   5'h0A, 32'h8000_0001, 32'h0800_0000, "R3");
        idle(1);
        // R4 parameterised index drops bits 7:5
        issue(0, 1, 8'hE5,  5'h02, 32'h0000_5000, 32'h0004_0000, "R4");
        issue(1, 1, 8'hFF,  5'h01, 32'h0000_5002, 32'h0004_0000, "R4");
        idle(1);
        // R5 long parameter
        issue(1, 1, 8'd31,  5'h1F, 32'h0000_6000, 32'h0010_0000, "R5");
        issue(1, 1, 8'd0,   5'h10, 32'h0000_6002, 32'h0010_0000, "R5");
        idle(1);
        // R6 short parameter, bits 4:3 ignored
        issue(0, 1, 8'd3,   5'h1D, 32'h0000_7000, 32'h0020_0000, "R6");
        issue(0, 1, 8'd3,   5'h18, 32'h0000_7000, 32'h0020_0000, "R6");
        idle(1);
        // R7 non-parameterised forms ignore value
        issue(0, 0, 8'd9,   5'h1F, 32'h0000_8000, 32'h0030_0000, "R7");
        issue(1, 0, 8'd9,   5'h1F, 32'h0000_8000, 32'h0030_0000, "R7");
        idle(1);
        // R8 back-to-back alternating forms
        for (int k = 0; k < 8; k++) begin
            issue(k[0], k[1], 8'(k * 37), 5'(k * 5), 32'h0000_9000 + 32'(k * 2),
                  32'h0040_0000 + 32'(k * 32'h100), "R8");
        end
        idle(3);
        done = 1'b1;
        @(posedge clk);
        #2;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule